// File: doc/BRIEF.md
# Decode-Stage Register Conflict Stall Unit

This block sits beside the decode/register-fetch stage of a five-stage in-order pipeline: fetch, decode, execute, memory, write-back. It has no operand forwarding. Every cycle it takes the two source register fields of the instruction being decoded and compares each one with the destination register of the three older instructions still in flight, in execute, memory and write-back.

The write-back stage is part of the comparison because the register file cannot accept a write and return the new value in the same cycle. When a source that the instruction really reads matches a live destination, the unit raises a stall in that same cycle. The stall does three things:
- it blocks the PC update;
- it blocks the fetch/decode register update, so the same instruction is fetched and decoded again on the next cycle;
- it forces to zero the control word handed to execute, so that a bubble enters execute.

For the instruction in execute, the unit picks the destination itself. It uses either the rt or the rd field of that instruction, selected by the register-destination bit carried with it.

Top module: `hazard_stall_unit`

## Requirements
- R1: The two sources are taken from `id_instr` bits [25:21] (first operand) and [20:16] (second operand). No other instruction bit affects the stall.
- R2: A read source equal to the execute-stage destination stalls when `ex_wen`=1. That destination is `ex_rd` when `ex_regdst`=1 and `ex_rt` when `ex_regdst`=0.
- R3: A read source equal to `mem_dst` stalls when `mem_wen`=1.
- R4: A read source equal to `wb_dst` stalls when `wb_wen`=1, because a same-cycle write cannot be read back.
- R5: A stage whose write enable is 0 never causes a stall, whatever its destination number.
- R6: A destination of register 0 never causes a stall.
- R7: The first source is compared only when `id_use_a`=1, and the second only when `id_use_b`=1.
- R8: `stall` is combinational. It follows the inputs in the same cycle, with no clock edge in between.
- R9: While `stall`=1, `pc_load_en` and `ifid_load_en` are 0. Otherwise both are 1.
- R10: While `stall`=1, `ex_ctrl` is all zeros. Otherwise `ex_ctrl` equals `id_ctrl`.
- R11: When no read source matches any enabled non-zero destination, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in decode |
| id_use_a | input | 1 | Decoding instruction reads its first operand |
| id_use_b | input | 1 | Decoding instruction reads its second operand |
| id_ctrl | input | 8 | Decoded control word bound for execute |
| ex_rt | input | 5 | rt field of the instruction in execute |
| ex_rd | input | 5 | rd field of the instruction in execute |
| ex_regdst | input | 1 | Execute instruction writes rd (1) or rt (0) |
| ex_wen | input | 1 | Execute instruction writes a register |
| mem_dst | input | 5 | Destination of the instruction in memory |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination of the instruction in write-back |
| wb_wen | input | 1 | Write-back instruction writes a register |
| stall | output | 1 | Register conflict detected this cycle |
| pc_load_en | output | 1 | PC may take its next value |
| ifid_load_en | output | 1 | Fetch/decode register may load |
| ex_ctrl | output | 8 | Control word into execute, zeroed on stall |

## Verification
On every evaluation, the assertions check the following:
- the bubble content and the pass-through of the control word;
- that the hold enables oppose the stall;
- that a match against write-back always stalls;
- that with no write enables, no read operands or only register-0 destinations there is never a stall.

Some behaviours are shown only by the bench's vector table and directed cases:
- the selection between rt and rd for the execute stage;
- that the unused instruction bits have no effect;
- that a single matching stage, or a single read operand, is enough to stall;
- that the stall follows the inputs before any clock edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    ST_EX  = 2'd0,
    ST_MEM = 2'd1,
    ST_WB  = 2'd2
  } hz_stage_e;

  localparam int unsigned N_STAGES  = 3;
  localparam int unsigned N_SOURCES = 2;
endpackage

// File: rtl/hz_dest_sel.sv
module hz_dest_sel #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  input  logic             regdst,
  output logic [REG_W-1:0] dst
);
  function automatic logic [REG_W-1:0] pick(input logic [REG_W-1:0] t,
                                            input logic [REG_W-1:0] d,
                                            input logic sel);
    return sel ? d : t;
  endfunction

  assign dst = pick(rt, rd, regdst);
endmodule

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  // register 0 is never a real producer
  function automatic logic conflict(input logic [REG_W-1:0] s, input logic u,
                                    input logic [REG_W-1:0] d, input logic w);
    return u && w && (d != '0) && (s == d);
  endfunction

  assign hit = conflict(src, used, dst, wen);
endmodule

// File: rtl/hz_bubble.sv
module hz_bubble #(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              stall,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              pc_load_en,
  output logic              ifid_load_en
);
  assign ctrl_out     = stall ? '0 : ctrl_in;
  assign pc_load_en   = ~stall;
  assign ifid_load_en = ~stall;
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned CTRL_W  = 8
) (
  input  logic [INSTR_W-1:0] id_instr,
  input  logic               id_use_a,
  input  logic               id_use_b,
  input  logic [CTRL_W-1:0]  id_ctrl,
  input  logic [REG_W-1:0]   ex_rt,
  input  logic [REG_W-1:0]   ex_rd,
  input  logic               ex_regdst,
  input  logic               ex_wen,
  input  logic [REG_W-1:0]   mem_dst,
  input  logic               mem_wen,
  input  logic [REG_W-1:0]   wb_dst,
  input  logic               wb_wen,
  output logic               stall,
  output logic               pc_load_en,
  output logic               ifid_load_en,
  output logic [CTRL_W-1:0]  ex_ctrl
);
  import hz_pkg::*;

  localparam int unsigned RD_LSB = 11;
  localparam int unsigned RT_LSB = RD_LSB + REG_W;
  localparam int unsigned RS_LSB = RT_LSB + REG_W;

  logic [REG_W-1:0] src_num [N_SOURCES];
  logic             src_use [N_SOURCES];
  logic [REG_W-1:0] stg_dst [N_STAGES];
  logic             stg_wen [N_STAGES];
  logic [N_STAGES-1:0] hit_a;
  logic [N_STAGES-1:0] hit_b;
  logic             hit_ex, hit_mem, hit_wb;
  logic [REG_W-1:0] ex_dst;
  logic             unused_instr_bits;

  assign src_num[0] = id_instr[RS_LSB +: REG_W];
  assign src_num[1] = id_instr[RT_LSB +: REG_W];
  assign src_use[0] = id_use_a;
  assign src_use[1] = id_use_b;
  assign unused_instr_bits = ^{id_instr[INSTR_W-1:RS_LSB+REG_W], id_instr[RT_LSB-1:0]};

  hz_dest_sel #(.REG_W(REG_W)) u_ex_dst (
    .rt(ex_rt), .rd(ex_rd), .regdst(ex_regdst), .dst(ex_dst)
  );

  assign stg_dst[ST_EX]  = ex_dst;
  assign stg_wen[ST_EX]  = ex_wen;
  assign stg_dst[ST_MEM] = mem_dst;
  assign stg_wen[ST_MEM] = mem_wen;
  assign stg_dst[ST_WB]  = wb_dst;
  assign stg_wen[ST_WB]  = wb_wen;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    hz_src_cmp #(.REG_W(REG_W)) u_cmp_a (
      .src(src_num[0]), .used(src_use[0]),
      .dst(stg_dst[s]), .wen(stg_wen[s]), .hit(hit_a[s])
    );
    hz_src_cmp #(.REG_W(REG_W)) u_cmp_b (
      .src(src_num[1]), .used(src_use[1]),
      .dst(stg_dst[s]), .wen(stg_wen[s]), .hit(hit_b[s])
    );
  end

  assign hit_ex  = hit_a[ST_EX]  | hit_b[ST_EX];
  assign hit_mem = hit_a[ST_MEM] | hit_b[ST_MEM];
  assign hit_wb  = hit_a[ST_WB]  | hit_b[ST_WB];
  assign stall   = hit_ex | hit_mem | hit_wb;

  hz_bubble #(.CTRL_W(CTRL_W)) u_bubble (
    .stall(stall), .ctrl_in(id_ctrl), .ctrl_out(ex_ctrl),
    .pc_load_en(pc_load_en), .ifid_load_en(ifid_load_en)
  );
endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned CTRL_W  = 8
) (
  input logic [INSTR_W-1:0] id_instr,
  input logic               id_use_a,
  input logic               id_use_b,
  input logic [CTRL_W-1:0]  id_ctrl,
  input logic [REG_W-1:0]   ex_rt,
  input logic [REG_W-1:0]   ex_rd,
  input logic               ex_wen,
  input logic [REG_W-1:0]   mem_dst,
  input logic               mem_wen,
  input logic [REG_W-1:0]   wb_dst,
  input logic               wb_wen,
  input logic               stall,
  input logic               pc_load_en,
  input logic               ifid_load_en,
  input logic [CTRL_W-1:0]  ex_ctrl
);
  always_comb begin
    if (stall) begin
      p_bubble_zero_r10: assert (ex_ctrl == '0) else $error("bubble not zero");
    end else begin
      p_ctrl_pass_r10: assert (ex_ctrl == id_ctrl) else $error("ctrl altered");
    end
    p_hold_r9: assert (pc_load_en == ifid_load_en && pc_load_en == !stall)
      else $error("hold enables wrong");
    if (wb_wen && wb_dst != '0 &&
        ((id_use_a && id_instr[25:21] == wb_dst) || (id_use_b && id_instr[20:16] == wb_dst))) begin
      p_wb_conflict_r4: assert (stall) else $error("write-back match without stall");
    end
    if (!ex_wen && !mem_wen && !wb_wen) begin
      p_no_wen_r5: assert (!stall) else $error("stall with no writers");
    end
    if (ex_rt == '0 && ex_rd == '0 && mem_dst == '0 && wb_dst == '0) begin
      p_zero_dst_r6: assert (!stall) else $error("stall on register 0");
    end
    if (!id_use_a && !id_use_b) begin
      p_no_read_r7: assert (!stall) else $error("stall with no reads");
    end
  end
endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(
  .INSTR_W(INSTR_W), .REG_W(REG_W), .CTRL_W(CTRL_W)
) u_chk (
  .id_instr(id_instr), .id_use_a(id_use_a), .id_use_b(id_use_b), .id_ctrl(id_ctrl),
  .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen),
  .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
  .stall(stall), .pc_load_en(pc_load_en), .ifid_load_en(ifid_load_en), .ex_ctrl(ex_ctrl)
);

// File: tb/hazard_stall_unit_tb.sv
module hazard_stall_unit_tb;
  logic        clk = 1'b0;
  logic [31:0] id_instr;
  logic        id_use_a, id_use_b;
  logic [7:0]  id_ctrl;
  logic [4:0]  ex_rt, ex_rd, mem_dst, wb_dst;
  logic        ex_regdst, ex_wen, mem_wen, wb_wen;
  logic        stall, pc_load_en, ifid_load_en;
  logic [7:0]  ex_ctrl;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hazard_stall_unit u_dut (
    .id_instr(id_instr), .id_use_a(id_use_a), .id_use_b(id_use_b), .id_ctrl(id_ctrl),
    .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_regdst(ex_regdst), .ex_wen(ex_wen),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .stall(stall), .pc_load_en(pc_load_en), .ifid_load_en(ifid_load_en), .ex_ctrl(ex_ctrl)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] rs, rt;
    logic       ua, ub;
    logic [4:0] ext, exd;
    logic       exdst, exw;
    logic [4:0] md;
    logic       mw;
    logic [4:0] wd;
    logic       ww;
    logic       exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd11, 5'd1,  5'd2,  1'b1, 1'b1, 5'd3, 5'd4,  1'b1, 1'b1, 5'd5,  1'b1, 5'd6,  1'b1, 1'b0}, // R11
    '{4'd2,  5'd4,  5'd2,  1'b1, 1'b1, 5'd9, 5'd4,  1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1}, // R2 rd
    '{4'd2,  5'd9,  5'd2,  1'b1, 1'b1, 5'd9, 5'd4,  1'b0, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1}, // R2 rt
    '{4'd2,  5'd4,  5'd2,  1'b1, 1'b1, 5'd9, 5'd4,  1'b0, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0}, // R2 rd unselected
    '{4'd3,  5'd1,  5'd7,  1'b1, 1'b1, 5'd0, 5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 5'd0,  1'b0, 1'b1}, // R3
    '{4'd4,  5'd8,  5'd2,  1'b1, 1'b1, 5'd0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd8,  1'b1, 1'b1}, // R4
    '{4'd5,  5'd8,  5'd8,  1'b1, 1'b1, 5'd8, 5'd8,  1'b1, 1'b0, 5'd8,  1'b0, 5'd8,  1'b0, 1'b0}, // R5
    '{4'd6,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0}, // R6
    '{4'd7,  5'd1,  5'd7,  1'b1, 1'b0, 5'd0, 5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 5'd0,  1'b0, 1'b0}, // R7 b unread
    '{4'd7,  5'd8,  5'd2,  1'b0, 1'b1, 5'd0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd8,  1'b1, 1'b0}, // R7 a unread
    '{4'd7,  5'd3,  5'd12, 1'b0, 1'b1, 5'd0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd12, 1'b1, 1'b1}, // R7 b read
    '{4'd2,  5'd13, 5'd13, 1'b1, 1'b1, 5'd0, 5'd13, 1'b1, 1'b1, 5'd13, 1'b1, 5'd13, 1'b1, 1'b1}, // R2 all match
    '{4'd1,  5'd31, 5'd0,  1'b1, 1'b0, 5'd0, 5'd31, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1}  // R1 top field
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R9 and R10 follow from the expected stall value
  task automatic check_outputs(input string tag, input logic exp_stall);
    check({tag, " stall"}, {31'd0, stall}, {31'd0, exp_stall});
    check("R9 pc_load_en", {31'd0, pc_load_en}, {31'd0, ~exp_stall});
    check("R9 ifid_load_en", {31'd0, ifid_load_en}, {31'd0, ~exp_stall});
    check("R10 ex_ctrl", {24'd0, ex_ctrl}, {24'd0, (exp_stall ? 8'h00 : id_ctrl)});
  endtask

  task automatic apply(input vec_t v);
    id_instr  = {6'h23, v.rs, v.rt, 5'd17, 11'h2A5};
    id_use_a  = v.ua;   id_use_b = v.ub;
    ex_rt     = v.ext;  ex_rd    = v.exd;  ex_regdst = v.exdst; ex_wen = v.exw;
    mem_dst   = v.md;   mem_wen  = v.mw;
    wb_dst    = v.wd;   wb_wen   = v.ww;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    id_instr = '0; id_use_a = 0; id_use_b = 0; id_ctrl = 8'hA5;
    ex_rt = 0; ex_rd = 0; ex_regdst = 0; ex_wen = 0;
    mem_dst = 0; mem_wen = 0; wb_dst = 0; wb_wen = 0;
    @(negedge clk);
    check_outputs("R11 idle", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      id_ctrl = 8'h5A ^ 8'(i * 37);
      apply(VEC[i]);
      @(negedge clk);
      check_outputs($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
    end

    // R1: rd field and opcode bits match the execute destination but are not sources
    @(posedge clk);
    apply('{4'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd0, 5'd17, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0});
    id_instr[31:26] = 6'd17;
    @(negedge clk);
    check_outputs("R1 non-source bits", 1'b0);

    // R8: stall follows inputs within a cycle, with no edge between
    @(posedge clk);
    apply('{4'd8, 5'd6, 5'd7, 1'b1, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 1'b1});
    #0.5;
    check("R8 same-cycle rise", {31'd0, stall}, 32'd1);
    mem_wen = 1'b0;
    #0.5;
    check("R8 same-cycle fall", {31'd0, stall}, 32'd0);
    check("R10 ctrl restored", {24'd0, ex_ctrl}, {24'd0, id_ctrl});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule